// File: doc/BRIEF.md
# Two-Thread Partitioned Queue

This block buffers work items from two hardware threads in a single pool of entries and hands them out as two independent first-in first-out streams. Every entry records which thread wrote it, and each thread reaches its own entries through a private chain of links (head, tail, occupancy). Free entries are drawn from a shared pool, so storage is spread out by need and not by fixed address ranges.

A mode input sets how much of the pool each thread may hold. With both threads running, each thread is capped at half of the pool, so a thread whose consumer has stopped cannot fill the buffer and starve the other. With one thread running, that thread may use the whole pool and the idle thread may not push. The read side serves the two threads in turn and skips a thread that has nothing to give, so one empty or stalled thread never costs the other a read slot.

Top module: `thread_split_queue`

## Requirements
- R1: After reset both threads are empty (`empty` = 2'b11), neither thread is full (`full` = 2'b00, with `dual_mode` high), and `pop_valid` is low.
- R2: With `dual_mode` high, a thread holding DEPTH/2 entries has its `full` bit set, and a push to it raises `push_rej` in the same cycle and stores nothing.
- R3: With `dual_mode` low, the thread named by `solo_tid` may hold all DEPTH entries, and every push to the other thread is refused with `push_rej`.
- R4: When `dual_mode` rises while a thread holds more than DEPTH/2 entries, that thread's pushes stay refused until its occupancy falls below DEPTH/2; the other thread may meanwhile push up to its own half while free entries remain.
- R5: While `pop_req` is high and both threads hold entries, successive reads serve thread 0 and thread 1 alternately; after reset the first turn belongs to thread 0, and after each read the turn passes to the thread not just served.
- R6: If `pop_req` is high and the thread whose turn it is holds nothing, the other thread is read in that same cycle.
- R7: Each thread's data leaves in the order it was accepted, and `pop_tid` gives the thread (0 or 1) the entry came from.
- R8: `pop_valid`, `pop_tid` and `pop_data` are registered: they show the read chosen in the cycle before; `pop_valid` is low after a cycle with `pop_req` low or with both threads empty.
- R9: A push and a read in the same cycle both take effect, also on the same thread holding one entry; an entry accepted in a cycle cannot be read in that cycle.
- R10: A push is refused whenever all DEPTH entries are occupied, even if the target thread is below its own cap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 1: both threads active, half cap each; 0: one thread active |
| solo_tid | input | 1 | Active thread when `dual_mode` is 0 |
| push_valid | input | 1 | Push request |
| push_tid | input | 1 | Thread of the pushed item |
| push_data | input | DW | Pushed item |
| push_rej | output | 1 | Push refused this cycle |
| pop_req | input | 1 | Consumer ready to take one item |
| pop_valid | output | 1 | Registered: an item was read |
| pop_tid | output | 1 | Registered: thread of the item read |
| pop_data | output | DW | Registered: item read |
| full | output | 2 | Per-thread: next push to this thread would be refused |
| empty | output | 2 | Per-thread: thread holds no entries |

## Verification
Push and read can land in the same cycle, on the same thread or on different ones, and the sharp case is a thread with a single entry that is read while a new item is linked behind it. The bench drives a push and `pop_req` together on such a thread and on a thread at its cap, and a behavioural model built from plain queues predicts the refused flag that cycle and the item, thread and order on the registered read port one cycle later. A long random phase with mode changes repeats this against the model on every clock.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int NTHR = 2;
  typedef enum logic {
    THR_A = 1'b0,
    THR_B = 1'b1
  } thr_e;
endpackage

// File: rtl/tsq_free_list.sv
// Pool of unused slots: bitmap with a lowest-index-first allocator.
module tsq_free_list #(
  parameter int DEPTH = 8,
  parameter int IDXW  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_en,
  input  logic            rel_en,
  input  logic [IDXW-1:0] rel_idx,
  output logic [IDXW-1:0] alloc_idx,
  output logic            any_free
);
  logic [DEPTH-1:0] free_q;
  logic [DEPTH-1:0] clr_m;
  logic [DEPTH-1:0] set_m;

  always_comb begin
    alloc_idx = '0;
    any_free  = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (free_q[i]) begin
        alloc_idx = IDXW'(i);
        any_free  = 1'b1;
      end
    end
  end

  always_comb begin
    clr_m = '0;
    set_m = '0;
    if (alloc_en) clr_m[alloc_idx] = 1'b1;
    if (rel_en)   set_m[rel_idx]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) free_q <= '1;
    else     free_q <= (free_q & ~clr_m) | set_m;
  end
endmodule

// File: rtl/tsq_thread_ptrs.sv
// Per-thread chain state: head slot, tail slot, occupancy.
module tsq_thread_ptrs #(
  parameter int IDXW = 3,
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_en,
  input  logic            pop_en,
  input  logic [IDXW-1:0] alloc_idx,
  input  logic [IDXW-1:0] head_link,
  output logic [IDXW-1:0] head,
  output logic [IDXW-1:0] tail,
  output logic [CNTW-1:0] cnt
);
  logic last_one;
  assign last_one = (cnt == CNTW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      cnt <= cnt + CNTW'(push_en) - CNTW'(pop_en);
      if (push_en) tail <= alloc_idx;
      if (pop_en) begin
        // single entry leaving while a new one arrives: link not yet written
        head <= (push_en && last_one) ? alloc_idx : head_link;
      end else if (push_en && cnt == '0) begin
        head <= alloc_idx;
      end
    end
  end
endmodule

// File: rtl/tsq_pop_turn.sv
// Alternating read selection with skip of an empty thread.
module tsq_pop_turn
  import tsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pop_req,
  input  logic [1:0] nonempty,
  output logic       pop_en,
  output logic       pop_sel
);
  thr_e turn_q;
  thr_e pick;

  always_comb begin
    if (nonempty[turn_q]) pick = turn_q;
    else                  pick = (turn_q == THR_A) ? THR_B : THR_A;
  end

  assign pop_en  = pop_req & (|nonempty);
  assign pop_sel = pick;

  always_ff @(posedge clk) begin
    if (rst)         turn_q <= THR_A;
    else if (pop_en) turn_q <= (pick == THR_A) ? THR_B : THR_A;
  end
endmodule

// File: rtl/thread_split_queue.sv
module thread_split_queue
  import tsq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dual_mode,
  input  logic          solo_tid,
  input  logic          push_valid,
  input  logic          push_tid,
  input  logic [DW-1:0] push_data,
  output logic          push_rej,
  input  logic          pop_req,
  output logic          pop_valid,
  output logic          pop_tid,
  output logic [DW-1:0] pop_data,
  output logic [1:0]    full,
  output logic [1:0]    empty
);
  localparam int HALF = DEPTH / 2;
  localparam int IDXW = $clog2(DEPTH);
  localparam int CNTW = IDXW + 1;

  // slot storage: thread tag + payload, and the chain link of each slot
  logic [DW:0]     slot_mem [DEPTH];
  logic [IDXW-1:0] link_mem [DEPTH];

  logic [IDXW-1:0] head_w [NTHR];
  logic [IDXW-1:0] tail_w [NTHR];
  logic [CNTW-1:0] cnt_w  [NTHR];
  logic [IDXW-1:0] link_w [NTHR];
  logic [NTHR-1:0] push_en;
  logic [NTHR-1:0] pop_en_t;
  logic [NTHR-1:0] room;
  logic [NTHR-1:0] nonempty;

  logic            any_free;
  logic [IDXW-1:0] alloc_idx;
  logic            push_acc;
  logic            pop_en;
  logic            pop_sel;
  logic [IDXW-1:0] rd_idx;
  logic [DW:0]     rd_word;

  genvar t;
  generate
    for (t = 0; t < NTHR; t++) begin : g_thr
      logic [CNTW-1:0] cap;
      always_comb begin
        if (dual_mode)                 cap = CNTW'(HALF);
        else if (solo_tid == 1'(t))    cap = CNTW'(DEPTH);
        else                           cap = '0;
      end
      assign room[t]     = cnt_w[t] < cap;
      assign full[t]     = ~(room[t] & any_free);
      assign nonempty[t] = (cnt_w[t] != '0);
      assign empty[t]    = ~nonempty[t];
      assign push_en[t]  = push_acc & (push_tid == 1'(t));
      assign pop_en_t[t] = pop_en & (pop_sel == 1'(t));
      assign link_w[t]   = link_mem[head_w[t]];

      tsq_thread_ptrs #(.IDXW(IDXW), .CNTW(CNTW)) u_ptrs (
        .clk       (clk),
        .rst       (rst),
        .push_en   (push_en[t]),
        .pop_en    (pop_en_t[t]),
        .alloc_idx (alloc_idx),
        .head_link (link_w[t]),
        .head      (head_w[t]),
        .tail      (tail_w[t]),
        .cnt       (cnt_w[t])
      );
    end
  endgenerate

  assign push_acc = push_valid & ~full[push_tid];
  assign push_rej = push_valid &  full[push_tid];

  tsq_free_list #(.DEPTH(DEPTH), .IDXW(IDXW)) u_free (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (push_acc),
    .rel_en    (pop_en),
    .rel_idx   (rd_idx),
    .alloc_idx (alloc_idx),
    .any_free  (any_free)
  );

  tsq_pop_turn u_turn (
    .clk      (clk),
    .rst      (rst),
    .pop_req  (pop_req),
    .nonempty (nonempty),
    .pop_en   (pop_en),
    .pop_sel  (pop_sel)
  );

  assign rd_idx  = head_w[pop_sel];
  assign rd_word = slot_mem[rd_idx];

  always_ff @(posedge clk) begin
    if (push_acc) slot_mem[alloc_idx] <= {push_tid, push_data};
  end

  always_ff @(posedge clk) begin
    if (push_acc && cnt_w[push_tid] != '0) link_mem[tail_w[push_tid]] <= alloc_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_valid <= 1'b0;
      pop_tid   <= 1'b0;
      pop_data  <= '0;
    end else begin
      pop_valid <= pop_en;
      if (pop_en) begin
        pop_tid  <= rd_word[DW];
        pop_data <= rd_word[DW-1:0];
      end
    end
  end
endmodule

// File: rtl/tsq_checker.sv
module tsq_checker #(
  parameter int DEPTH = 8,
  parameter int CNTW  = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            dual_mode,
  input logic            solo_tid,
  input logic            pop_req,
  input logic            pop_valid,
  input logic            pop_tid,
  input logic [1:0]      empty,
  input logic [CNTW-1:0] cnt0,
  input logic [CNTW-1:0] cnt1
);
  localparam int HALF = DEPTH / 2;

  // R2: at or above the half cap in dual mode, a thread does not grow
  p_cap_a_r2: assert property (@(posedge clk) disable iff (rst)
    (dual_mode && int'(cnt0) >= HALF) |=> (cnt0 <= $past(cnt0)));
  p_cap_b_r2: assert property (@(posedge clk) disable iff (rst)
    (dual_mode && int'(cnt1) >= HALF) |=> (cnt1 <= $past(cnt1)));

  // R3: the idle thread in solo mode never grows
  p_idle_a_r3: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && solo_tid) |=> (cnt0 <= $past(cnt0)));
  p_idle_b_r3: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && !solo_tid) |=> (cnt1 <= $past(cnt1)));

  // R10: the two chains never hold more than the pool
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt0) + int'(cnt1) <= DEPTH));

  // R5: back-to-back reads with both threads occupied change thread
  p_alternate_r5: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty == 2'b00 && $past(pop_req && empty == 2'b00))
    |=> (pop_tid != $past(pop_tid)));

  // R6: a request with any occupied thread always yields a read
  p_skip_r6: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty != 2'b11) |=> pop_valid);

  // R8: no request or nothing stored gives no read
  p_no_read_r8: assert property (@(posedge clk) disable iff (rst)
    (!pop_req || empty == 2'b11) |=> !pop_valid);
endmodule

bind thread_split_queue tsq_checker #(.DEPTH(DEPTH), .CNTW(CNTW)) u_tsq_chk (
  .clk       (clk),
  .rst       (rst),
  .dual_mode (dual_mode),
  .solo_tid  (solo_tid),
  .pop_req   (pop_req),
  .pop_valid (pop_valid),
  .pop_tid   (pop_tid),
  .empty     (empty),
  .cnt0      (cnt_w[0]),
  .cnt1      (cnt_w[1])
);

// File: tb/thread_split_queue_test.sv
module thread_split_queue_test;
  localparam int DEPTH = 8;
  localparam int DW    = 16;
  localparam int HALF  = DEPTH / 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          dual_mode, solo_tid;
  logic          push_valid, push_tid, pop_req;
  logic [DW-1:0] push_data;
  logic          push_rej, pop_valid, pop_tid;
  logic [DW-1:0] pop_data;
  logic [1:0]    full, empty;

  int n_run  = 0;
  int n_fail = 0;
  string tag = "R1";

  int mq0[$];
  int mq1[$];
  bit mturn = 1'b0;

  always #4 clk = ~clk;

  thread_split_queue #(.DEPTH(DEPTH), .DW(DW)) uut (
    .clk(clk), .rst(rst), .dual_mode(dual_mode), .solo_tid(solo_tid),
    .push_valid(push_valid), .push_tid(push_tid), .push_data(push_data),
    .push_rej(push_rej), .pop_req(pop_req), .pop_valid(pop_valid),
    .pop_tid(pop_tid), .pop_data(pop_data), .full(full), .empty(empty)
  );

  task automatic chk(bit ok, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int qsize(bit t);
    return t ? mq1.size() : mq0.size();
  endfunction

  // one clock: drive, check flags, advance model, check registered read
  task automatic cyc(bit pv, bit pt, int pd, bit pr);
    bit [1:0] efull, eempty;
    bit erej, have, sel;
    int cap, tot, edata;
    push_valid = pv; push_tid = pt; push_data = DW'(pd); pop_req = pr;
    #1;
    tot = mq0.size() + mq1.size();
    for (int t = 0; t < 2; t++) begin
      if (dual_mode) cap = HALF;
      else if (solo_tid == 1'(t)) cap = DEPTH;
      else cap = 0;
      efull[t]  = !(qsize(1'(t)) < cap && tot < DEPTH);
      eempty[t] = (qsize(1'(t)) == 0);
    end
    erej = pv && efull[pt];
    chk(full == efull, "full", int'(full), int'(efull));
    chk(empty == eempty, "empty", int'(empty), int'(eempty));
    chk(push_rej == erej, "push_rej", int'(push_rej), int'(erej));
    have = pr && (tot != 0);
    sel = (qsize(mturn) != 0) ? mturn : !mturn;
    edata = 0;
    if (have) begin
      if (sel) edata = mq1.pop_front(); else edata = mq0.pop_front();
      mturn = !sel;
    end
    if (pv && !erej) begin
      if (pt) mq1.push_back(pd); else mq0.push_back(pd);
    end
    @(posedge clk);
    #1;
    chk(pop_valid == have, "R8 pop_valid", int'(pop_valid), int'(have));
    if (have) begin
      chk(pop_tid == sel, "R7 pop_tid", int'(pop_tid), int'(sel));
      chk(int'(pop_data) == edata, "R7 pop_data", int'(pop_data), edata);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; dual_mode = 1'b1; solo_tid = 1'b0;
    push_valid = 1'b0; push_tid = 1'b0; push_data = '0; pop_req = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    tag = "R1";
    cyc(0, 0, 0, 0);

    tag = "R2";   // fifth push to thread 0 is refused
    for (int i = 0; i < 5; i++) cyc(1, 0, 10 + i, 0);
    for (int i = 0; i < 5; i++) cyc(1, 1, 100 + i, 0);

    tag = "R5";   // both occupied: 0,1,0,1
    repeat (4) cyc(0, 0, 0, 1);

    tag = "R6";   // fill thread 1, drain: thread 0 runs dry first
    cyc(1, 1, 120, 0);
    cyc(1, 1, 121, 0);
    repeat (6) cyc(0, 0, 0, 1);

    tag = "R8";   // requests with nothing stored
    repeat (3) cyc(0, 0, 0, 1);

    tag = "R9";   // push and read on a one-entry thread
    cyc(1, 0, 300, 0);
    cyc(1, 0, 301, 1);
    cyc(1, 0, 302, 1);
    cyc(1, 1, 303, 1);
    repeat (2) cyc(0, 0, 0, 1);

    tag = "R3";   // solo thread 1 takes the whole pool
    dual_mode = 1'b0; solo_tid = 1'b1;
    for (int i = 0; i < 9; i++) cyc(1, 1, 400 + i, 0);
    cyc(1, 0, 499, 0);

    tag = "R10";  // switch solo thread while the pool is full
    solo_tid = 1'b0;
    cyc(1, 0, 500, 0);
    repeat (3) cyc(0, 0, 0, 1);
    for (int i = 0; i < 4; i++) cyc(1, 0, 510 + i, 0);

    tag = "R4";   // back to dual mode with thread 1 above half
    dual_mode = 1'b1;
    for (int i = 0; i < 5; i++) begin
      cyc(1, 1, 600 + i, 1);
      cyc(1, 0, 620 + i, 0);
    end
    repeat (4) cyc(1, 1, 650, 1);

    tag = "R7";   // random traffic with mode changes
    for (int i = 0; i < 4000; i++) begin
      if (i % 97 == 0) begin
        dual_mode = ($urandom_range(3) != 0);
        solo_tid  = 1'($urandom_range(1));
      end
      cyc(1'($urandom_range(1)), 1'($urandom_range(1)),
          int'($urandom_range(65535)), ($urandom_range(2) == 0));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule